// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block orders the power-up of a PCIe root port. It starts on a `start` pulse. It first holds the endpoint in reset with the PHY in test power-down, the reference clock off and link training disabled. It then releases the endpoint reset and keeps training disabled for one more cycle. After that it powers the slot, takes the PHY out of power-down and enables the reference clock. Next it raises the clock-enable requests one at a time and waits for each acknowledge. It waits a stabilization time, enables link training, and samples a link-up input a bounded number of times.

Every delay is a parameter counted in clock cycles, so a simulation can use short values and silicon can use the real hold and settle times. When an acknowledge does not arrive within its timeout, the block withdraws the clock requests already granted, one per cycle, from the newest to the oldest, and reports a clock error. The result flags are `done`, `linkFail` and `clkErr`. Each stays asserted until the next accepted `start`.

Top module: `pcie_rp_bringup`

## Requirements
- R1: While reset is asserted and after it, until the first start: epResetN=0, phyTestPd=1, refClkEn=0, powerOn=0, ltssmEn=0, clkReq=0, and busy, done, linkFail and clkErr are 0.
- R2: After an accepted start, epResetN is low for exactly HOLD_CYC cycles. During that time phyTestPd=1, refClkEn=0, ltssmEn=0 and clkReq=0.
- R3: In the first cycle with epResetN high, phyTestPd is still 1 and ltssmEn is 0. In the next cycle powerOn=1 (when POWER_ON_EN=1), phyTestPd=0, refClkEn=1 and clkReq is still 0.
- R4: Clock requests rise one bit per step, starting at bit 0, so clkReq always has the form 2^n-1. Bit n+1 is raised only after clkAck[n] has been seen high. A granted request stays high.
- R5: If clkAck[n] stays low for ACK_TMO cycles, the requests are cleared one bit per cycle from bit n down to bit 0, and then clkErr is set. ltssmEn never rises in this case, and refClkEn stays 1.
- R6: ltssmEn rises exactly STAB_CYC+1 cycles after the cycle in which clkReq first becomes all ones.
- R7: linkUp is sampled in the first cycle of ltssmEn and then every POLL_GAP cycles. done is set in the cycle after the first sample that sees it high, including the last permitted sample.
- R8: If MAX_POLLS samples all see linkUp low, linkFail is set POLL_GAP*(MAX_POLLS-1)+1 cycles after ltssmEn rose, and done stays 0.
- R9: done, linkFail and clkErr are mutually exclusive. Each is held, with all outputs unchanged, until the next start, whatever linkUp does.
- R10: A start while busy=1 is ignored. In particular, it does not lengthen the reset hold.
- R11: A start while done, linkFail or clkErr is set restarts the sequence: in the next cycle the flags, clkReq, ltssmEn and epResetN are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the sequence (when not busy) |
| clkAck | input | NUM_CLK | Acknowledge per clock-enable request |
| linkUp | input | 1 | Link-up status from the controller |
| epResetN | output | 1 | Endpoint reset, active low |
| phyTestPd | output | 1 | PHY test power-down |
| refClkEn | output | 1 | Reference clock enable |
| powerOn | output | 1 | Slot power enable |
| clkReq | output | NUM_CLK | Clock-enable requests, bit 0 first |
| ltssmEn | output | 1 | Link training enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Link came up |
| linkFail | output | 1 | Link never came up within the poll budget |
| clkErr | output | 1 | A clock acknowledge timed out |

## Verification
Two events can fall in the same cycle: a linkUp sample that sees the link high, and the exhaustion of the poll budget. Whether that cycle ends in done or in linkFail depends on the order in which the two are evaluated. The bench provokes this by raising linkUp exactly on the last permitted sample. It expects done, not linkFail, with a latency of POLL_GAP*(MAX_POLLS-1)+1 cycles from the rise of ltssmEn. A second coincidence is also exercised: linkUp already high on the first cycle of ltssmEn must finish the sequence one cycle later.

// File: rtl/pcie_rp_bringup_pkg.sv
package pcie_rp_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_PREP, ST_REL, ST_CLKREQ,
    ST_UNWIND, ST_STAB, ST_POLL, ST_DONE, ST_FAIL, ST_ERR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHold;
    logic loadAck;
    logic loadStab;
    logic loadGap;
    logic tmrDec;
    logic reqFirst;
    logic reqNext;
    logic reqDrop;
    logic reqClrAll;
    logic idxDec;
    logic pollClr;
    logic pollInc;
  } seqStrobe_t;

endpackage

// File: rtl/pcie_rp_bringup_dp.sv
module pcie_rp_bringup_dp
  import pcie_rp_bringup_pkg::*;
#(
  parameter int NUM_CLK   = 4,
  parameter int HOLD_CYC  = 2000,
  parameter int STAB_CYC  = 300,
  parameter int ACK_TMO   = 16,
  parameter int POLL_GAP  = 100,
  parameter int MAX_POLLS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [NUM_CLK-1:0] clkAck,
  output logic [NUM_CLK-1:0] clkReq,
  output logic               tmrZero,
  output logic               ackCur,
  output logic               idxLast,
  output logic               idxZero,
  output logic               pollLast
);
  localparam int MAX_A  = (HOLD_CYC > STAB_CYC) ? HOLD_CYC : STAB_CYC;
  localparam int MAX_B  = (ACK_TMO > POLL_GAP) ? ACK_TMO : POLL_GAP;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_C + 1);
  localparam int IDX_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  logic [TMR_W-1:0]  tmr;
  logic [IDX_W-1:0]  clkIdx;
  logic [IDX_W-1:0]  idxNxt;
  logic [POLL_W-1:0] pollCnt;

  assign idxNxt = clkIdx + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.loadHold) begin
      tmr <= TMR_W'(HOLD_CYC - 1);
    end else if (stb.loadAck) begin
      tmr <= TMR_W'(ACK_TMO - 1);
    end else if (stb.loadStab) begin
      tmr <= TMR_W'(STAB_CYC - 1);
    end else if (stb.loadGap) begin
      tmr <= TMR_W'(POLL_GAP - 1);
    end else if (stb.tmrDec) begin
      tmr <= tmr - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkIdx <= '0;
      clkReq <= '0;
    end else begin
      if (stb.reqClrAll) begin
        clkReq <= '0;
      end else if (stb.reqFirst) begin
        clkReq[0] <= 1'b1;
      end else if (stb.reqNext) begin
        clkReq[idxNxt] <= 1'b1;
      end else if (stb.reqDrop) begin
        clkReq[clkIdx] <= 1'b0;
      end
      if (stb.reqFirst) begin
        clkIdx <= '0;
      end else if (stb.reqNext) begin
        clkIdx <= idxNxt;
      end else if (stb.idxDec) begin
        clkIdx <= clkIdx - IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (stb.pollClr) begin
      pollCnt <= '0;
    end else if (stb.pollInc) begin
      pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  assign tmrZero  = (tmr == '0);
  assign ackCur   = clkAck[clkIdx];
  assign idxLast  = (clkIdx == IDX_W'(NUM_CLK - 1));
  assign idxZero  = (clkIdx == '0);
  assign pollLast = (pollCnt == POLL_W'(MAX_POLLS - 1));

endmodule

// File: rtl/pcie_rp_bringup_ctrl.sv
module pcie_rp_bringup_ctrl
  import pcie_rp_bringup_pkg::*;
#(
  parameter bit POWER_ON_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       linkUp,
  input  logic       tmrZero,
  input  logic       ackCur,
  input  logic       idxLast,
  input  logic       idxZero,
  input  logic       pollLast,
  output seqStrobe_t stb,
  output logic       epResetN,
  output logic       phyTestPd,
  output logic       refClkEn,
  output logic       powerOn,
  output logic       ltssmEn,
  output logic       busy,
  output logic       done,
  output logic       linkFail,
  output logic       clkErr
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL, ST_ERR: begin
        if (start) begin
          stb.loadHold  = 1'b1;
          stb.reqClrAll = 1'b1;
          stateNxt      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmrZero) stateNxt = ST_PREP;
        else         stb.tmrDec = 1'b1;
      end
      ST_PREP: stateNxt = ST_REL;
      ST_REL: begin
        stb.reqFirst = 1'b1;
        stb.loadAck  = 1'b1;
        stateNxt     = ST_CLKREQ;
      end
      ST_CLKREQ: begin
        if (ackCur) begin
          if (idxLast) begin
            stb.loadStab = 1'b1;
            stateNxt     = ST_STAB;
          end else begin
            stb.reqNext = 1'b1;
            stb.loadAck = 1'b1;
          end
        end else if (tmrZero) begin
          stateNxt = ST_UNWIND;
        end else begin
          stb.tmrDec = 1'b1;
        end
      end
      ST_UNWIND: begin
        stb.reqDrop = 1'b1;
        if (idxZero) stateNxt = ST_ERR;
        else         stb.idxDec = 1'b1;
      end
      ST_STAB: begin
        if (tmrZero) begin
          stb.pollClr = 1'b1;
          stateNxt    = ST_POLL;
        end else begin
          stb.tmrDec = 1'b1;
        end
      end
      ST_POLL: begin
        if (tmrZero) begin
          if (linkUp) begin
            stateNxt = ST_DONE;
          end else if (pollLast) begin
            stateNxt = ST_FAIL;
          end else begin
            stb.pollInc = 1'b1;
            stb.loadGap = 1'b1;
          end
        end else begin
          stb.tmrDec = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  logic relPhase;
  assign relPhase  = !(state inside {ST_IDLE, ST_HOLD, ST_PREP});
  assign epResetN  = !(state inside {ST_IDLE, ST_HOLD});
  assign phyTestPd = !relPhase;
  assign refClkEn  = relPhase;
  assign powerOn   = POWER_ON_EN && relPhase;
  assign ltssmEn   = state inside {ST_POLL, ST_DONE, ST_FAIL};
  assign busy      = !(state inside {ST_IDLE, ST_DONE, ST_FAIL, ST_ERR});
  assign done      = (state == ST_DONE);
  assign linkFail  = (state == ST_FAIL);
  assign clkErr    = (state == ST_ERR);

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
  import pcie_rp_bringup_pkg::*;
#(
  parameter int NUM_CLK     = 4,
  parameter int HOLD_CYC    = 2000,
  parameter int STAB_CYC    = 300,
  parameter int ACK_TMO     = 16,
  parameter int POLL_GAP    = 100,
  parameter int MAX_POLLS   = 10,
  parameter bit POWER_ON_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NUM_CLK-1:0] clkAck,
  input  logic               linkUp,
  output logic               epResetN,
  output logic               phyTestPd,
  output logic               refClkEn,
  output logic               powerOn,
  output logic [NUM_CLK-1:0] clkReq,
  output logic               ltssmEn,
  output logic               busy,
  output logic               done,
  output logic               linkFail,
  output logic               clkErr
);
  seqStrobe_t stb;
  logic tmrZero, ackCur, idxLast, idxZero, pollLast;

  pcie_rp_bringup_ctrl #(.POWER_ON_EN(POWER_ON_EN)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .linkUp(linkUp),
    .tmrZero(tmrZero), .ackCur(ackCur), .idxLast(idxLast),
    .idxZero(idxZero), .pollLast(pollLast), .stb(stb),
    .epResetN(epResetN), .phyTestPd(phyTestPd), .refClkEn(refClkEn),
    .powerOn(powerOn), .ltssmEn(ltssmEn), .busy(busy), .done(done),
    .linkFail(linkFail), .clkErr(clkErr)
  );

  pcie_rp_bringup_dp #(
    .NUM_CLK(NUM_CLK), .HOLD_CYC(HOLD_CYC), .STAB_CYC(STAB_CYC),
    .ACK_TMO(ACK_TMO), .POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .clkAck(clkAck), .clkReq(clkReq),
    .tmrZero(tmrZero), .ackCur(ackCur), .idxLast(idxLast),
    .idxZero(idxZero), .pollLast(pollLast)
  );

endmodule

// File: rtl/pcie_rp_bringup_chk.sv
module pcie_rp_bringup_chk #(
  parameter int NUM_CLK = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               epResetN,
  input logic               phyTestPd,
  input logic               refClkEn,
  input logic               ltssmEn,
  input logic [NUM_CLK-1:0] clkReq,
  input logic               done,
  input logic               linkFail,
  input logic               clkErr
);
  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !epResetN |-> (phyTestPd && !refClkEn && !ltssmEn));

  // R3
  refclk_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refClkEn) |-> (epResetN && !phyTestPd && $past(epResetN)));

  // R4
  req_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkReq & (clkReq + NUM_CLK'(1))) == '0);

  // R4
  req_rise_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> ($countones(clkReq) <= $countones($past(clkReq)) + 1));

  // R5
  req_fall_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> ($countones($past(clkReq)) <= $countones(clkReq) + 1));

  // R6
  ltssm_needs_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    ltssmEn |-> (&clkReq));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, linkFail, clkErr}));

  // R9
  done_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R9
  fail_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((linkFail || clkErr) && !start) |=> $stable({linkFail, clkErr}));

endmodule

bind pcie_rp_bringup pcie_rp_bringup_chk #(.NUM_CLK(NUM_CLK)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .epResetN(epResetN),
  .phyTestPd(phyTestPd), .refClkEn(refClkEn), .ltssmEn(ltssmEn),
  .clkReq(clkReq), .done(done), .linkFail(linkFail), .clkErr(clkErr)
);

// File: tb/pcie_rp_bringup_tb_top.sv
module pcie_rp_bringup_tb_top;
  localparam int NCLK = 4;
  localparam int HOLD = 20;
  localparam int STAB = 10;
  localparam int ACKT = 8;
  localparam int GAP  = 5;
  localparam int MAXP = 10;
  localparam int NV   = 7;
  // outcome: 0 done, 1 linkFail, 2 clkErr; delay -1 means link never up
  localparam int vMask[NV] = '{15, 15, 15, 15, 0, 7, 11};
  localparam int vDly[NV]  = '{0, 12, 45, -1, 0, 0, 0};
  localparam int vOut[NV]  = '{0, 0, 0, 1, 2, 2, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic linkUp = 1'b0;
  logic [NCLK-1:0] ackMask = '0;
  logic [NCLK-1:0] clkAck;
  logic epResetN, phyTestPd, refClkEn, powerOn, ltssmEn, busy, done, linkFail, clkErr;
  logic [NCLK-1:0] clkReq;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;
  assign clkAck = clkReq & ackMask;

  pcie_rp_bringup #(
    .NUM_CLK(NCLK), .HOLD_CYC(HOLD), .STAB_CYC(STAB), .ACK_TMO(ACKT),
    .POLL_GAP(GAP), .MAX_POLLS(MAXP), .POWER_ON_EN(1'b1)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .clkAck(clkAck), .linkUp(linkUp),
    .epResetN(epResetN), .phyTestPd(phyTestPd), .refClkEn(refClkEn),
    .powerOn(powerOn), .clkReq(clkReq), .ltssmEn(ltssmEn), .busy(busy),
    .done(done), .linkFail(linkFail), .clkErr(clkErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input logic [NCLK-1:0] mask, input int dly, input int expOut, input bit poke);
    int holdCnt, cyc, ltssmAt, allOnAt, drops, failIdx, k, expLat;
    logic [NCLK-1:0] prev, heldReq;
    bit orderOk, unwOk;
    ackMask = mask;
    linkUp  = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R11 restart clears everything; R2 hold outputs
    chk(!epResetN && !done && !linkFail && !clkErr, "R11", {epResetN, done, linkFail, clkErr}, 0);
    chk(clkReq == '0 && !ltssmEn, "R11", {clkReq, ltssmEn}, 0);
    chk(phyTestPd && !refClkEn, "R2", {phyTestPd, refClkEn}, 2);
    holdCnt = 0;
    while (!epResetN && holdCnt < 1000) begin
      holdCnt++;
      start = (poke && holdCnt == 5);
      @(negedge clk);
    end
    start = 1'b0;
    chk(holdCnt == HOLD, poke ? "R10" : "R2", holdCnt, HOLD);
    chk(phyTestPd && !ltssmEn && !refClkEn, "R3", {phyTestPd, ltssmEn, refClkEn}, 4);
    @(negedge clk);
    chk(powerOn && !phyTestPd && refClkEn && clkReq == '0, "R3",
        {powerOn, phyTestPd, refClkEn}, 5);
    prev = clkReq; cyc = 0; ltssmAt = -1; allOnAt = -1; drops = 0;
    orderOk = 1'b1; unwOk = 1'b1;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (clkReq != prev) begin
        if (clkReq > prev) begin
          if (clkReq != ((prev << 1) | NCLK'(1))) orderOk = 1'b0;
        end else begin
          drops++;
          if (clkReq != (prev >> 1)) unwOk = 1'b0;
        end
      end
      if (&clkReq && allOnAt < 0) allOnAt = cyc;
      if (ltssmEn && ltssmAt < 0) ltssmAt = cyc;
      if (ltssmAt >= 0 && dly >= 0 && cyc - ltssmAt >= dly) linkUp = 1'b1;
      prev = clkReq;
    end
    chk(orderOk, "R4", 0, 1);
    if (expOut == 2) begin
      failIdx = 0;
      while (failIdx < NCLK && mask[failIdx]) failIdx++;
      chk(clkErr && !done && !linkFail, "R5", {done, linkFail, clkErr}, 1);
      chk(unwOk && drops == failIdx + 1, "R5", drops, failIdx + 1);
      chk(clkReq == '0 && ltssmAt < 0 && refClkEn, "R5", clkReq, 0);
    end else begin
      chk(ltssmAt == allOnAt + STAB + 1, "R6", ltssmAt - allOnAt, STAB + 1);
      chk(&clkReq, "R4", clkReq, 15);
      if (expOut == 0) begin
        k = (dly + GAP - 1) / GAP;
        expLat = k * GAP + 1;
        chk(done && !linkFail, "R7", {done, linkFail}, 2);
        chk(cyc - ltssmAt == expLat, "R7", cyc - ltssmAt, expLat);
      end else begin
        expLat = GAP * (MAXP - 1) + 1;
        chk(linkFail && !done, "R8", {done, linkFail}, 1);
        chk(cyc - ltssmAt == expLat, "R8", cyc - ltssmAt, expLat);
      end
    end
    // R9 result held while linkUp wanders
    heldReq = clkReq;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      linkUp = ~linkUp;
    end
    chk(done == (expOut == 0) && linkFail == (expOut == 1) && clkErr == (expOut == 2)
        && clkReq == heldReq && !busy, "R9", {done, linkFail, clkErr}, expOut);
    linkUp = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    nBad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values, during and after reset
    chk(!epResetN && phyTestPd && !refClkEn && !powerOn && !ltssmEn && clkReq == '0,
        "R1", {epResetN, phyTestPd, refClkEn, powerOn, ltssmEn}, 8);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !linkFail && !clkErr && !epResetN && !refClkEn, "R1",
        {busy, done, linkFail, clkErr}, 0);
    for (int v = 0; v < NV; v++) begin
      runSeq(NCLK'(vMask[v]), vDly[v], vOut[v], 1'b0);
    end
    // R10 start pulsed in the middle of the hold
    runSeq(4'hF, 7, 0, 1'b1);
    // R11 restart from clock error state
    runSeq(4'h3, 0, 2, 1'b0);
    runSeq(4'hF, 3, 0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule